// File: doc/BRIEF.md
# Platform Reset Control Port

This block is a single byte-wide register on the I/O bus. Software uses it to ask for a platform reset and to pick which kind of reset that should be. The block watches an I/O write strobe, an I/O read strobe, a 16-bit port address and an 8-bit write data byte. It responds only at port 0xCF9.

A write whose trigger bit is clear updates the stored reset-type flag. A write whose trigger bit is set does not touch the flag. Instead it raises a one-clock reset request toward the platform reset logic. A read returns the stored byte one clock later, together with a data-valid flag. The reset sequencer that consumes the request is a separate block.

Top module: `reset_ctl_port`

## Requirements
- R1: A synchronous active-high reset clears the stored reset-type flag to 0 and drives the reset request and read-valid outputs low.
- R2: Only accesses at port address 0xCF9 (all 16 address bits compared) have any effect. Writes elsewhere change no stored state and raise no request. Reads elsewhere raise no read-valid and return zero data.
- R3: A write to 0xCF9 with data bit 2 clear stores data bit 1 as the reset-type flag. The new value is visible to a read issued on the next cycle.
- R4: All write data bits other than bit 1 are discarded. Read data has every bit except bit 1 at zero.
- R5: A write to 0xCF9 with data bit 2 set drives the reset request high for exactly the one clock after the write. The stored reset-type flag is left unchanged.
- R6: A read strobe at 0xCF9 drives read-valid high on the next clock, with read data equal to the stored byte. When read-valid is low, read data is zero.
- R7: When a read and a write to 0xCF9 occur in the same cycle, the read returns the value stored before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| io_wr | input | 1 | I/O write strobe |
| io_rd | input | 1 | I/O read strobe |
| io_addr | input | 16 | I/O port address |
| io_wdata | input | 8 | I/O write data |
| io_rdata | output | 8 | Read data, valid with io_rvalid |
| io_rvalid | output | 1 | Read data valid, one clock after a decoded read |
| sys_rst_req | output | 1 | One-clock platform reset request |

## Verification
The following properties are checked on every cycle:
- Each reset request traces back to a decoded trigger write on the previous cycle.
- Each read-valid traces back to a decoded read.
- Read data never has bits set outside the reset-type position, and is zero while idle.
- A trigger write leaves the stored flag untouched.

The directed scenarios cover behaviour that needs a value history:
- The flag actually captured from write data.
- Accesses at nearby and aliased addresses being ignored.
- The pulse dropping after a single clock.
- A read that collides with a write returning the old value.

// File: rtl/reset_ctl_pkg.sv
package reset_ctl_pkg;

    localparam int unsigned IO_ADDR_W   = 16;
    localparam int unsigned IO_DATA_W   = 8;
    localparam logic [15:0] CTL_PORT    = 16'hCF9;
    localparam int unsigned TYPE_POS    = 1;
    localparam int unsigned TRIGGER_POS = 2;

    // Decoded write command: the only two data bits with meaning
    typedef struct packed {
        logic trigger;
        logic rst_type;
    } wr_cmd_t;

    // Place the stored flag at its bit position in a zeroed byte
    function automatic logic [IO_DATA_W-1:0] pack_flag(input logic flag);
        logic [IO_DATA_W-1:0] b;
        b = '0;
        b[TYPE_POS] = flag;
        return b;
    endfunction

endpackage

// File: rtl/reset_ctl_decode.sv
module reset_ctl_decode #(
    parameter int unsigned          ADDR_W = reset_ctl_pkg::IO_ADDR_W,
    parameter logic [ADDR_W-1:0]    PORT   = ADDR_W'(reset_ctl_pkg::CTL_PORT)
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr,
    input  logic              rd,
    output logic              wr_hit,
    output logic              rd_hit
);

    logic addr_match;

    always_comb begin
        addr_match = (addr == PORT);
        wr_hit     = wr && addr_match;
        rd_hit     = rd && addr_match;
    end

endmodule

// File: rtl/reset_ctl_store.sv
module reset_ctl_store
    import reset_ctl_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    wr_hit,
    input  wr_cmd_t cmd,
    output logic    type_q,
    output logic    req_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            type_q <= 1'b0;
            req_q  <= 1'b0;
        end else begin
            req_q <= wr_hit && cmd.trigger;
            if (wr_hit && !cmd.trigger) begin
                type_q <= cmd.rst_type;
            end
        end
    end

    // R5
    trigger_keeps_type_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_hit && cmd.trigger) |=> $stable(type_q));

endmodule

// File: rtl/reset_ctl_readback.sv
module reset_ctl_readback
    import reset_ctl_pkg::*;
#(
    parameter int unsigned DATA_W = IO_DATA_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_hit,
    input  logic              type_q,
    output logic [DATA_W-1:0] rdata,
    output logic              rvalid
);

    logic rflag_q;
    logic rvalid_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            rvalid_q <= 1'b0;
            rflag_q  <= 1'b0;
        end else begin
            rvalid_q <= rd_hit;
            rflag_q  <= rd_hit ? type_q : 1'b0;
        end
    end

    always_comb begin
        rdata  = DATA_W'(pack_flag(rflag_q && rvalid_q));
        rvalid = rvalid_q;
    end

endmodule

// File: rtl/reset_ctl_port.sv
module reset_ctl_port
    import reset_ctl_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 io_wr,
    input  logic                 io_rd,
    input  logic [IO_ADDR_W-1:0] io_addr,
    input  logic [IO_DATA_W-1:0] io_wdata,
    output logic [IO_DATA_W-1:0] io_rdata,
    output logic                 io_rvalid,
    output logic                 sys_rst_req
);

    logic    wr_hit;
    logic    rd_hit;
    logic    type_q;
    wr_cmd_t cmd;
    logic    wdata_unused;

    always_comb begin
        cmd.trigger  = io_wdata[TRIGGER_POS];
        cmd.rst_type = io_wdata[TYPE_POS];
        wdata_unused = ^io_wdata;
    end

    reset_ctl_decode #(
        .ADDR_W (IO_ADDR_W),
        .PORT   (CTL_PORT)
    ) u_decode (
        .addr   (io_addr),
        .wr     (io_wr),
        .rd     (io_rd),
        .wr_hit (wr_hit),
        .rd_hit (rd_hit)
    );

    reset_ctl_store u_store (
        .clk    (clk),
        .rst    (rst),
        .wr_hit (wr_hit),
        .cmd    (cmd),
        .type_q (type_q),
        .req_q  (sys_rst_req)
    );

    reset_ctl_readback #(
        .DATA_W (IO_DATA_W)
    ) u_readback (
        .clk    (clk),
        .rst    (rst),
        .rd_hit (rd_hit),
        .type_q (type_q),
        .rdata  (io_rdata),
        .rvalid (io_rvalid)
    );

    // R2 R5
    req_has_cause_chk: assert property (@(posedge clk) disable iff (rst)
        sys_rst_req |-> $past(io_wr && (io_addr == CTL_PORT) && io_wdata[TRIGGER_POS]));

    // R2 R6
    rvalid_has_cause_chk: assert property (@(posedge clk) disable iff (rst)
        io_rvalid |-> $past(io_rd && (io_addr == CTL_PORT)));

    // R4
    rdata_only_type_chk: assert property (@(posedge clk) disable iff (rst)
        (io_rdata & ~pack_flag(1'b1)) == '0);

    // R6
    rdata_idle_zero_chk: assert property (@(posedge clk) disable iff (rst)
        !io_rvalid |-> (io_rdata == '0));

    // R1
    reset_clears_chk: assert property (@(posedge clk)
        $past(rst) |-> (!sys_rst_req && !io_rvalid));

endmodule

// File: tb/test_reset_ctl_port.sv
module test_reset_ctl_port;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       io_wr = 1'b0;
    logic       io_rd = 1'b0;
    logic [15:0] io_addr = '0;
    logic [7:0] io_wdata = '0;
    logic [7:0] io_rdata;
    logic       io_rvalid;
    logic       sys_rst_req;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    logic [7:0] s_rdata;
    logic       s_rvalid;
    logic       s_req;

    always #4 clk = ~clk;

    reset_ctl_port i_reset_ctl_port (
        .clk         (clk),
        .rst         (rst),
        .io_wr       (io_wr),
        .io_rd       (io_rd),
        .io_addr     (io_addr),
        .io_wdata    (io_wdata),
        .io_rdata    (io_rdata),
        .io_rvalid   (io_rvalid),
        .sys_rst_req (sys_rst_req)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Drive one cycle of strobes at a falling edge, sample after the next rising edge
    task automatic cycle(input logic wr, input logic rd, input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        io_wr = wr; io_rd = rd; io_addr = a; io_wdata = d;
        @(negedge clk);
        s_rdata = io_rdata; s_rvalid = io_rvalid; s_req = sys_rst_req;
        io_wr = 1'b0; io_rd = 1'b0; io_addr = '0; io_wdata = '0;
    endtask

    task automatic read_expect(input string req, input logic [7:0] exp);
        cycle(1'b0, 1'b1, 16'hCF9, 8'h00);
        check({req, " rvalid"}, {7'd0, s_rvalid}, 8'h01);
        check({req, " rdata"}, s_rdata, exp);
    endtask

    task automatic t_reset;
        @(negedge clk);
        check("R1 req", {7'd0, sys_rst_req}, 8'h00);
        check("R1 rvalid", {7'd0, io_rvalid}, 8'h00);
        check("R6 idle rdata", io_rdata, 8'h00);
        read_expect("R1", 8'h00);
    endtask

    task automatic t_store;
        cycle(1'b1, 1'b0, 16'hCF9, 8'h02);
        check("R3 no req", {7'd0, s_req}, 8'h00);
        read_expect("R3", 8'h02);
        cycle(1'b1, 1'b0, 16'hCF9, 8'h00);
        read_expect("R3 clear", 8'h00);
    endtask

    task automatic t_mask;
        cycle(1'b1, 1'b0, 16'hCF9, 8'hFB);
        check("R4 no req", {7'd0, s_req}, 8'h00);
        read_expect("R4 set", 8'h02);
        cycle(1'b1, 1'b0, 16'hCF9, 8'hF9);
        read_expect("R4 clear", 8'h00);
    endtask

    task automatic t_trigger;
        cycle(1'b1, 1'b0, 16'hCF9, 8'h02);
        cycle(1'b1, 1'b0, 16'hCF9, 8'h04);
        check("R5 pulse", {7'd0, s_req}, 8'h01);
        cycle(1'b0, 1'b0, 16'h0000, 8'h00);
        check("R5 one clock", {7'd0, s_req}, 8'h00);
        read_expect("R5 kept 1", 8'h02);
        cycle(1'b1, 1'b0, 16'hCF9, 8'h00);
        cycle(1'b1, 1'b0, 16'hCF9, 8'h06);
        check("R5 pulse b", {7'd0, s_req}, 8'h01);
        read_expect("R5 kept 0", 8'h00);
    endtask

    task automatic t_other_addr;
        cycle(1'b1, 1'b0, 16'hCF8, 8'h02);
        check("R2 cf8 req", {7'd0, s_req}, 8'h00);
        cycle(1'b1, 1'b0, 16'h1CF9, 8'h06);
        check("R2 alias req", {7'd0, s_req}, 8'h00);
        cycle(1'b1, 1'b0, 16'h0CFA, 8'h02);
        read_expect("R2 store", 8'h00);
        cycle(1'b0, 1'b1, 16'hCFA, 8'h00);
        check("R2 rd rvalid", {7'd0, s_rvalid}, 8'h00);
        check("R2 rd rdata", s_rdata, 8'h00);
    endtask

    task automatic t_collide;
        cycle(1'b1, 1'b1, 16'hCF9, 8'h02);
        check("R7 rvalid", {7'd0, s_rvalid}, 8'h01);
        check("R7 old", s_rdata, 8'h00);
        read_expect("R7 new", 8'h02);
    endtask

    task automatic t_rereset;
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        read_expect("R1 rereset", 8'h00);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_store();
        t_mask();
        t_trigger();
        t_other_addr();
        t_collide();
        t_rereset();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                n_checks++;
                n_fails++;
                $display("FAIL watchdog: actual hung expected done");
            end
        join_any
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

endmodule